// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a simple internal request port to an external asynchronous static RAM of 16-bit words. A client presents a read or write command together with a word address, write data and a two-bit byte mask. The controller then runs the memory's active-low chip select, output enable, write enable and per-byte lane enables through a fixed sequence of clock cycles. It also decides who may drive the shared data bus during each cycle.

Every access runs through the same sequence. There is one setup cycle, then a strobe window of a configurable number of cycles, then one hold cycle. Address and lane enables stay constant across the whole sequence. A read returns its data with a single-cycle valid pulse, and bytes that were not requested read as zero. A request whose mask selects no byte finishes on the spot and issues no strobes.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no access is active, the controller holds the following values: `req_ready` high, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` high, and `mem_dq_oe` low.
- R2: Suppose a request with a nonzero mask is sampled at a clock edge while `req_ready` is high. From the next cycle, `req_ready` is low and `mem_ce_n` is low for exactly ACC_CYC+2 cycles.
- R3: On a write, `mem_we_n` is low for exactly ACC_CYC cycles, beginning in the second cycle of the access. Chip select is already low in the cycle before `mem_we_n` falls. `mem_addr` equals the request address and stays stable for the whole access.
- R4: `req_mask` bit 0 selects data bits 7:0 and drives `mem_lb_n` low. Bit 1 selects bits 15:8 and drives `mem_ub_n` low. Each lane enable stays low for the whole access. A write leaves the stored byte of an unselected lane unchanged.
- R5: On a write, `mem_dq_oe` is high for the whole access and `mem_dq_out` carries the request data.
- R6: On a read, `mem_oe_n` is low for exactly ACC_CYC cycles, beginning in the second cycle of the access. During the read, `mem_we_n` stays high and `mem_dq_oe` stays low.
- R7: Read data is sampled from `mem_dq_in` at the last cycle of the output-enable window. It appears on `rsp_rdata` in the following cycle with a one-cycle `rsp_valid` pulse. Bytes of unselected lanes are zero.
- R8: `mem_oe_n` low and `mem_dq_oe` high never occur in the same cycle. When `mem_dq_oe` rises, at least two cycles have passed since `mem_oe_n` was last low.
- R9: A request with mask 2'b00 produces no strobe and no `rsp_valid`, and `req_ready` stays high.
- R10: A request presented while `req_ready` is low has no effect on the strobes, the bus or the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (18) | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select, bit 0 = low byte |
| req_ready | output | 1 | Controller idle, request accepted |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected bytes zero |
| mem_addr | output | AW (18) | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_dq_out | output | 16 | Data driven onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 16 | Data sampled from the bus |

## Verification
Two events can coincide. A read ends with its output enable released and its response presented, and a write request can be waiting in that same window. The bench provokes this by issuing the write immediately after the read finishes. It then confirms that the response pulse and the release of output enable land in the hold cycle, and that the write's bus drive starts only two or more cycles after output enable was last low. The bench also keeps a second request held on the input while an access is in flight. Its per-cycle model and a later read-back confirm that the second request left no trace.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW      = 18,
  parameter int ACC_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);
  localparam int CW = $clog2(ACC_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(ACC_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_HOLD} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic         wr_q;
  logic [AW-1:0] addr_q;
  logic [15:0]  wd_q;
  logic [1:0]   lane_q;
  logic [15:0]  lane_bits;

  wire busy   = (st != S_IDLE);
  wire strobe = (st == S_ACT);
  wire accept = req_valid && !busy && (req_mask != 2'b00);

  assign lane_bits  = {{8{lane_q[1]}}, {8{lane_q[0]}}};
  assign req_ready  = !busy;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !busy;
  assign mem_we_n   = !(strobe && wr_q);
  assign mem_oe_n   = !(strobe && !wr_q);
  assign mem_lb_n   = !(busy && lane_q[0]);
  assign mem_ub_n   = !(busy && lane_q[1]);
  assign mem_dq_oe  = busy && wr_q;
  assign mem_dq_out = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wd_q      <= '0;
      lane_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          wr_q   <= req_write;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          lane_q <= req_mask;
          st     <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_ACT;
        end
        S_ACT: if (cnt == LAST) begin
          st <= S_HOLD;
          if (!wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_in & lane_bits;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: begin
          st     <= S_IDLE;
          lane_q <= '0;
        end
      endcase
    end
  end

  // R8
  no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && mem_oe_n));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R3
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  rsp_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(!mem_oe_n));

  // R6
  read_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  // R9
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_mask == 2'b00) |=> (req_ready && mem_ce_n));
endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  localparam int AW  = 18;
  localparam int ACC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hFFFF;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sram_lane_ctrl #(.AW(AW), .ACC_CYC(ACC)) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // emulated memory driven only by the strobes
  logic [15:0] emem [int];
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] old;
      old = emem.exists(int'(mem_addr)) ? emem[int'(mem_addr)] : 16'h0;
      if (!mem_lb_n) old[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) old[15:8] = mem_dq_out[15:8];
      emem[int'(mem_addr)] = old;
    end
  end
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      logic [15:0] v;
      v = emem.exists(int'(mem_addr)) ? emem[int'(mem_addr)] : 16'h0;
      mem_dq_in <= {mem_ub_n ? 8'hA5 : v[15:8], mem_lb_n ? 8'hA5 : v[7:0]};
    end else begin
      mem_dq_in <= 16'hFFFF;
    end
  end

  // behavioural reference model
  logic [15:0] shadow [int];
  bit m_busy = 0, m_wr = 0, e_rv = 0;
  int ph = 0;
  logic [AW-1:0] m_addr = '0;
  logic [15:0] m_wd = '0, e_rd = '0;
  logic [1:0] m_mask = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; ph = 0; e_rv = 0;
    end else begin
      e_rv = 0;
      if (m_busy) begin
        if (ph == ACC + 1) m_busy = 0; else ph++;
      end else if (req_valid && req_mask != 2'b00) begin
        logic [15:0] s;
        m_busy = 1; ph = 0; m_wr = req_write; m_addr = req_addr;
        m_wd = req_wdata; m_mask = req_mask;
        s = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 16'h0;
        if (req_write) begin
          if (req_mask[0]) s[7:0]  = req_wdata[7:0];
          if (req_mask[1]) s[15:8] = req_wdata[15:8];
          shadow[int'(req_addr)] = s;
        end else begin
          e_rd = s & {{8{req_mask[1]}}, {8{req_mask[0]}}};
        end
      end
      if (m_busy && !m_wr && ph == ACC + 1) e_rv = 1;
    end
  end

  int since_oe = 100;
  logic prev_dqoe = 1'b0;
  always @(negedge clk) if (rst_n) begin
    bit act;
    act = m_busy && ph >= 1 && ph <= ACC;
    chk("R1/R2 ready", req_ready, !m_busy);
    chk("R2 ce_n", mem_ce_n, !m_busy);
    chk("R3 we_n", mem_we_n, !(act && m_wr));
    chk("R6 oe_n", mem_oe_n, !(act && !m_wr));
    chk("R5 dq_oe", mem_dq_oe, m_busy && m_wr);
    chk("R4 lb_n", mem_lb_n, !(m_busy && m_mask[0]));
    chk("R4 ub_n", mem_ub_n, !(m_busy && m_mask[1]));
    chk("R7 rsp_valid", rsp_valid, e_rv);
    if (m_busy) chk("R3 addr", mem_addr, m_addr);
    if (m_busy && m_wr) chk("R5 dq_out", mem_dq_out, m_wd);
    if (e_rv) chk("R7 rdata", rsp_rdata, e_rd);
    if (!mem_oe_n) since_oe = 0; else since_oe++;
    if (!mem_oe_n && mem_dq_oe) chk("R8 clash", 1, 0);
    if (mem_dq_oe && !prev_dqoe) chk("R8 gap", since_oe >= 2, 1);
    prev_dqoe = mem_dq_oe;
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic read_expect(input logic [AW-1:0] a, input logic [1:0] m,
                             input logic [15:0] exp, input string tag);
    logic [15:0] got;
    got = 16'hxxxx;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) begin
      if (rsp_valid) got = rsp_rdata;
      @(negedge clk);
    end
    chk(tag, got, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 ce_n", mem_ce_n, 1);
    chk("R1 dq_oe", mem_dq_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes", {mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 4'hF);

    issue(1, 18'h00010, 16'h1234, 2'b11);
    read_expect(18'h00010, 2'b11, 16'h1234, "R7 full read");
    issue(1, 18'h00010, 16'hAB99, 2'b10);
    read_expect(18'h00010, 2'b01, 16'h0034, "R4/R7 low lane only");
    read_expect(18'h00010, 2'b10, 16'hAB00, "R4/R7 high lane only");
    read_expect(18'h00010, 2'b11, 16'hAB34, "R4 untouched low byte");

    // R9 empty mask
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 18'h00010; req_wdata = 16'hFFFF; req_mask = 2'b00;
    @(negedge clk);
    req_valid = 0;
    chk("R9 ready stays", req_ready, 1);
    chk("R9 no ce", mem_ce_n, 1);
    read_expect(18'h00010, 2'b11, 16'hAB34, "R9 no write");

    // R8 read directly followed by write
    read_expect(18'h00020, 2'b11, 16'h0000, "R8 read before write");
    issue(1, 18'h00020, 16'h5A5A, 2'b11);

    // R10 request held while busy
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 18'h3FFFF; req_wdata = 16'h00C3; req_mask = 2'b01;
    @(negedge clk);
    req_addr = 18'h00020; req_wdata = 16'hDEAD; req_mask = 2'b11;
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    read_expect(18'h00020, 2'b11, 16'h5A5A, "R10 busy request ignored");
    read_expect(18'h3FFFF, 2'b11, 16'h00C3, "R4 top address low lane");
    chk("R10 emulated memory", emem[int'(18'h00020)], 16'h5A5A);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule